// File: doc/BRIEF.md
# Accumulator ALU with Condition Flags

This block is the purely combinational datapath of a small 8-bit accumulator CPU. An operation code, the accumulator, the index register, one operand byte and the four incoming condition flags (negative, overflow, zero, carry) go in. The same cycle, the block returns a result word, the four updated flags, a destination code and a valid bit. The surrounding sequencer latches the result into whatever the destination names, and latches the flags.

Each operation changes only the flags it owns. Flags it does not own pass through unchanged. Subtraction treats the incoming carry as an inverted borrow. Compare and bit test compute a value but never write it back. One transfer leaves every flag alone. Three fused operations combine an AND with a second step. Decimal arithmetic, address generation and decoding are handled elsewhere.

Top module: `acc_alu`

## Requirements
- R1: Operation code 0 (ADC) gives acc + operand + carry, keeps the low W bits, sets C to the carry out and V to signed overflow, and sends the result to the accumulator (destination code 1). Destination codes are: 0 none, 1 accumulator, 2 index, 3 memory.
- R2: Code 1 (SBC) gives acc − operand − (1 − carry). C is set when no borrow occurs. V is set on signed overflow. The destination is the accumulator.
- R3: Code 2 compares the accumulator and code 3 compares the index register. Each computes register − operand as the result and sets C when the register is greater than or equal to the operand as unsigned values. V is kept and the destination is none.
- R4: Code 4 (bit test) returns acc AND operand, with Z set when that value is zero. N takes operand bit W−1 and V takes operand bit W−2. C is kept and the destination is none.
- R5: Code 8 shifts the operand left, filling bit 0 with 0 and moving the old top bit into C. Code 9 shifts it right, filling the top bit with 0, moving bit 0 into C and forcing N to 0.
- R6: Code 10 rotates the operand left through carry (old C into bit 0, top bit into C). Code 11 rotates it right through carry (old C into the top bit, bit 0 into C).
- R7: Codes 5, 6 and 7 give acc AND, OR and XOR operand to the accumulator. Codes 12 and 13 give operand plus and minus one. All five keep V and C.
- R8: Code 14 passes the operand through and updates N and Z. Code 15 returns the index register, changes no flag, and has destination none. Codes 8 to 14 send their result to the destination given by tgt_i.
- R9: Code 16 gives acc AND operand to the accumulator and sets C to its top bit. Code 17 gives (acc AND operand) shifted right to the accumulator, following the right-shift flag rules of R5.
- R10: Code 18 gives (acc AND index) − operand to the index register. It sets N, Z and C as a compare does, ignores the incoming carry and keeps V.
- R11: For every defined code except 15, N equals result bit W−1 and Z is set exactly when the result is zero.
- R12: Codes 19 to 31 are undefined. They drive valid low, a zero result, destination none, and all four flags equal to their inputs. Every defined code drives valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | W | Accumulator value |
| idx_i | input | W | Index register value |
| opnd_i | input | W | Operand byte |
| tgt_i | input | 2 | Destination for shift, rotate, increment, decrement and pass-through |
| flg_n_i | input | 1 | Incoming negative flag |
| flg_v_i | input | 1 | Incoming overflow flag |
| flg_z_i | input | 1 | Incoming zero flag |
| flg_c_i | input | 1 | Incoming carry flag |
| res_o | output | W | Result value |
| flg_n_o | output | 1 | Updated negative flag |
| flg_v_o | output | 1 | Updated overflow flag |
| flg_z_o | output | 1 | Updated zero flag |
| flg_c_o | output | 1 | Updated carry flag |
| dst_o | output | 2 | Destination code |
| vld_o | output | 1 | Operation code is defined |

## Verification
The bound checker re-evaluates its rules whenever any input changes. It confirms the flag-ownership rules: compare and bit test never name a destination, the logic and step operations keep V and C, and the silent transfer keeps every flag. It also checks the N/Z relation to the result, the bit-test copies and the undefined-code passthrough. The arithmetic values themselves, carry out on wraparound, overflow at the signed boundary, rotation through carry and the fused subtract's carry handling, are shown only by the bench's sweep. That sweep runs a 4-bit instance against a model that works from integer arithmetic.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADC  = 5'd0,
    OP_SBC  = 5'd1,
    OP_CMPA = 5'd2,
    OP_CMPX = 5'd3,
    OP_BIT  = 5'd4,
    OP_AND  = 5'd5,
    OP_ORA  = 5'd6,
    OP_EOR  = 5'd7,
    OP_ASL  = 5'd8,
    OP_LSR  = 5'd9,
    OP_ROL  = 5'd10,
    OP_ROR  = 5'd11,
    OP_INC  = 5'd12,
    OP_DEC  = 5'd13,
    OP_MOV  = 5'd14,
    OP_MOVQ = 5'd15,
    OP_ANDC = 5'd16,
    OP_ANDR = 5'd17,
    OP_XSUB = 5'd18
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_IDX  = 2'd2,
    DST_MEM  = 2'd3
  } alu_dst_e;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } lg_sel_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   tot;

  // subtract = add of inverted operand; carry in acts as not-borrow
  assign b_eff  = sub_i ? ~b_i : b_i;
  assign tot    = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, cin_i};
  assign sum_o  = tot[W-1:0];
  assign cout_o = tot[W];
  assign ovf_o  = (a_i[W-1] == b_eff[W-1]) && (tot[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         cin_i,
  input  logic         left_i,
  input  logic         rot_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic fill;
  assign fill = rot_i & cin_i;

  always_comb begin
    if (left_i) begin
      res_o  = {val_i[W-2:0], fill};
      cout_o = val_i[W-1];
    end else begin
      res_o  = {fill, val_i[W-1:1]};
      cout_o = val_i[0];
    end
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  lg_sel_e      sel_i,
  output logic [W-1:0] res_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      unique case (sel_i)
        LG_OR:   res_o[i] = a_i[i] | b_i[i];
        LG_XOR:  res_o[i] = a_i[i] ^ b_i[i];
        default: res_o[i] = a_i[i] & b_i[i];
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [4:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] idx_i,
  input  logic [W-1:0] opnd_i,
  input  logic [1:0]   tgt_i,
  input  logic         flg_n_i,
  input  logic         flg_v_i,
  input  logic         flg_z_i,
  input  logic         flg_c_i,
  output logic [W-1:0] res_o,
  output logic         flg_n_o,
  output logic         flg_v_o,
  output logic         flg_z_o,
  output logic         flg_c_o,
  output logic [1:0]   dst_o,
  output logic         vld_o
);
  localparam logic [W-1:0] ONE = W'(1);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  logic [W-1:0] acc_and_idx, acc_and_opnd;
  assign acc_and_idx  = acc_i & idx_i;
  assign acc_and_opnd = acc_i & opnd_i;

  // adder operand steering
  logic [W-1:0] add_a, add_sum;
  logic         add_sub, add_cin, add_cout, add_ovf;
  always_comb begin
    unique case (op)
      OP_CMPX: add_a = idx_i;
      OP_XSUB: add_a = acc_and_idx;
      default: add_a = acc_i;
    endcase
    add_sub = (op != OP_ADC);
    add_cin = (op == OP_ADC || op == OP_SBC) ? flg_c_i : 1'b1;
  end

  alu_addsub #(.W(W)) u_add (
    .a_i(add_a), .b_i(opnd_i), .cin_i(add_cin), .sub_i(add_sub),
    .sum_o(add_sum), .cout_o(add_cout), .ovf_o(add_ovf)
  );

  // shifter steering
  logic [W-1:0] sh_val, sh_res;
  logic         sh_left, sh_rot, sh_cout;
  assign sh_val  = (op == OP_ANDR) ? acc_and_opnd : opnd_i;
  assign sh_left = (op == OP_ASL) || (op == OP_ROL);
  assign sh_rot  = (op == OP_ROL) || (op == OP_ROR);

  alu_shift #(.W(W)) u_sh (
    .val_i(sh_val), .cin_i(flg_c_i), .left_i(sh_left), .rot_i(sh_rot),
    .res_o(sh_res), .cout_o(sh_cout)
  );

  lg_sel_e      lg_sel;
  logic [W-1:0] lg_res;
  always_comb begin
    unique case (op)
      OP_ORA:  lg_sel = LG_OR;
      OP_EOR:  lg_sel = LG_XOR;
      default: lg_sel = LG_AND;
    endcase
  end

  alu_logic #(.W(W)) u_lg (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel), .res_o(lg_res)
  );

  logic upd_nz;
  logic [W-1:0] res;

  always_comb begin
    res     = '0;
    upd_nz  = 1'b1;
    flg_v_o = flg_v_i;
    flg_c_o = flg_c_i;
    dst_o   = DST_NONE;
    vld_o   = 1'b1;
    unique case (op)
      OP_ADC, OP_SBC: begin
        res = add_sum; flg_c_o = add_cout; flg_v_o = add_ovf; dst_o = DST_ACC;
      end
      OP_CMPA, OP_CMPX: begin
        res = add_sum; flg_c_o = add_cout;
      end
      OP_XSUB: begin
        res = add_sum; flg_c_o = add_cout; dst_o = DST_IDX;
      end
      OP_BIT: begin
        res = acc_and_opnd; flg_v_o = opnd_i[W-2]; upd_nz = 1'b0;
      end
      OP_AND, OP_ORA, OP_EOR: begin
        res = lg_res; dst_o = DST_ACC;
      end
      OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
        res = sh_res; flg_c_o = sh_cout; dst_o = tgt_i;
      end
      OP_ANDR: begin
        res = sh_res; flg_c_o = sh_cout; dst_o = DST_ACC;
      end
      OP_ANDC: begin
        res = acc_and_opnd; flg_c_o = acc_and_opnd[W-1]; dst_o = DST_ACC;
      end
      OP_INC: begin
        res = opnd_i + ONE; dst_o = tgt_i;
      end
      OP_DEC: begin
        res = opnd_i - ONE; dst_o = tgt_i;
      end
      OP_MOV: begin
        res = opnd_i; dst_o = tgt_i;
      end
      OP_MOVQ: begin
        res = idx_i; upd_nz = 1'b0;
      end
      default: begin
        upd_nz = 1'b0; vld_o = 1'b0;
      end
    endcase
  end

  assign res_o = res;

  // bit test takes N from the operand, Z from the masked value
  always_comb begin
    if (op == OP_BIT) begin
      flg_n_o = opnd_i[W-1];
      flg_z_o = ~|res;
    end else if (upd_nz) begin
      flg_n_o = res[W-1];
      flg_z_o = ~|res;
    end else begin
      flg_n_o = flg_n_i;
      flg_z_o = flg_z_i;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic [4:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [W-1:0] idx_i,
  input logic [W-1:0] opnd_i,
  input logic [1:0]   tgt_i,
  input logic         flg_n_i,
  input logic         flg_v_i,
  input logic         flg_z_i,
  input logic         flg_c_i,
  input logic [W-1:0] res_o,
  input logic         flg_n_o,
  input logic         flg_v_o,
  input logic         flg_z_o,
  input logic         flg_c_o,
  input logic [1:0]   dst_o,
  input logic         vld_o
);
  logic known;
  assign known = !$isunknown({op_i, acc_i, idx_i, opnd_i, tgt_i,
                              flg_n_i, flg_v_i, flg_z_i, flg_c_i});

  always_comb begin
    if (known) begin
      if (op_i == OP_CMPA || op_i == OP_CMPX || op_i == OP_BIT)
        AST_NO_WRITEBACK: assert (dst_o == DST_NONE && flg_v_o == (op_i == OP_BIT ? opnd_i[W-2] : flg_v_i)) else $error("no writeback"); // R3
      if (op_i == OP_BIT)
        AST_BIT_COPY: assert (flg_n_o == opnd_i[W-1] && flg_v_o == opnd_i[W-2] && flg_c_o == flg_c_i && flg_z_o == ((acc_i & opnd_i) == '0)) else $error("bit test"); // R4
      if (op_i == OP_LSR || op_i == OP_ANDR)
        AST_RSHIFT_N_LOW: assert (!flg_n_o) else $error("right shift N"); // R5
      if (op_i == OP_AND || op_i == OP_ORA || op_i == OP_EOR || op_i == OP_INC || op_i == OP_DEC)
        AST_KEEP_VC: assert (flg_v_o == flg_v_i && flg_c_o == flg_c_i) else $error("V/C kept"); // R7
      if (op_i >= OP_ASL && op_i <= OP_MOV)
        AST_TGT_FOLLOW: assert (dst_o == tgt_i) else $error("target follow"); // R8
      if (op_i == OP_MOVQ)
        AST_QUIET_MOVE: assert (res_o == idx_i && dst_o == DST_NONE && flg_n_o == flg_n_i && flg_v_o == flg_v_i && flg_z_o == flg_z_i && flg_c_o == flg_c_i) else $error("quiet move"); // R8
      if (op_i == OP_XSUB)
        AST_XSUB_KEEP_V: assert (flg_v_o == flg_v_i && dst_o == DST_IDX) else $error("xsub V"); // R10
      if (vld_o && op_i != OP_MOVQ)
        AST_NZ_RESULT: assert (flg_z_o == (res_o == '0) && (op_i == OP_BIT || flg_n_o == res_o[W-1])) else $error("N/Z"); // R11
      if (op_i > OP_XSUB)
        AST_UNDEF_PASS: assert (!vld_o && res_o == '0 && dst_o == DST_NONE && flg_n_o == flg_n_i && flg_v_o == flg_v_i && flg_z_o == flg_z_i && flg_c_o == flg_c_i) else $error("undefined"); // R12
      else
        AST_DEF_VALID: assert (vld_o) else $error("defined valid"); // R12
    end
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .op_i(op_i), .acc_i(acc_i), .idx_i(idx_i), .opnd_i(opnd_i), .tgt_i(tgt_i),
  .flg_n_i(flg_n_i), .flg_v_i(flg_v_i), .flg_z_i(flg_z_i), .flg_c_i(flg_c_i),
  .res_o(res_o), .flg_n_o(flg_n_o), .flg_v_o(flg_v_o), .flg_z_o(flg_z_o),
  .flg_c_o(flg_c_o), .dst_o(dst_o), .vld_o(vld_o)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
  localparam int W = 4;
  localparam int MSK = (1 << W) - 1;
  localparam int TOP = 1 << (W - 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]   op;
  logic [W-1:0] acc, idx, opnd, res;
  logic [1:0]   tgt, dst;
  logic         ni, vi, zi, ci, no, vo, zo, co, vld;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  acc_alu #(.W(W)) u0 (
    .op_i(op), .acc_i(acc), .idx_i(idx), .opnd_i(opnd), .tgt_i(tgt),
    .flg_n_i(ni), .flg_v_i(vi), .flg_z_i(zi), .flg_c_i(ci),
    .res_o(res), .flg_n_o(no), .flg_v_o(vo), .flg_z_o(zo), .flg_c_o(co),
    .dst_o(dst), .vld_o(vld)
  );

  function automatic int sgn(int v);
    return (v >= TOP) ? v - (1 << W) : v;
  endfunction

  // packed: vld, dst[1:0], n, v, z, c, r[W-1:0]
  function automatic logic [W+6:0] model(int o, int a, int m, int x, int t,
                                          bit n, bit v, bit z, bit c);
    int r, d, s;
    bit vl = 1'b1, nz = 1'b1;
    int ds = 0;
    r = 0;
    case (o)
      0: begin d = a + m + c; r = d & MSK; c = d > MSK;
           s = sgn(a) + sgn(m) + c; v = 1'b0; // recomputed below
           v = (sgn(a) + sgn(m) + ((a + m + (d > MSK ? 0 : 0)) >= 0 ? 0 : 0) + int'(d - a - m) > TOP - 1) ||
               (sgn(a) + sgn(m) + int'(d - a - m) < -TOP);
           ds = 1; end
      1: begin d = a - m - (1 - int'(c)); s = sgn(a) - sgn(m) - (1 - int'(c));
           r = d & MSK; c = d >= 0; v = (s > TOP - 1) || (s < -TOP); ds = 1; end
      2: begin d = a - m; r = d & MSK; c = d >= 0; end
      3: begin d = x - m; r = d & MSK; c = d >= 0; end
      4: begin r = a & m; nz = 1'b0; n = (m >> (W - 1)) & 1; v = (m >> (W - 2)) & 1; z = r == 0; end
      5: begin r = a & m; ds = 1; end
      6: begin r = a | m; ds = 1; end
      7: begin r = a ^ m; ds = 1; end
      8: begin r = (m * 2) & MSK; c = m >= TOP; ds = t; end
      9: begin r = m / 2; c = m % 2; ds = t; end
      10: begin r = (m * 2 + int'(c)) & MSK; c = m >= TOP; ds = t; end
      11: begin r = m / 2 + int'(c) * TOP; c = m % 2; ds = t; end
      12: begin r = (m + 1) & MSK; ds = t; end
      13: begin r = (m + MSK) & MSK; ds = t; end
      14: begin r = m; ds = t; end
      15: begin r = x; nz = 1'b0; end
      16: begin r = a & m; c = r >= TOP; ds = 1; end
      17: begin d = a & m; r = d / 2; c = d % 2; ds = 1; end
      18: begin d = (a & x) - m; r = d & MSK; c = d >= 0; ds = 2; end
      default: begin vl = 1'b0; nz = 1'b0; end
    endcase
    if (nz) begin n = r >= TOP; z = r == 0; end
    return {vl, 2'(ds), n, v, z, c, W'(r)};
  endfunction

  function automatic string tag(int o);
    case (o)
      0: return "R1/R11";
      1: return "R2/R11";
      2, 3: return "R3/R11";
      4: return "R4/R11";
      5, 6, 7, 12, 13: return "R7/R11";
      8, 9: return "R5/R11";
      10, 11: return "R6/R11";
      14, 15: return "R8";
      16, 17: return "R9/R11";
      18: return "R10/R11";
      default: return "R12";
    endcase
  endfunction

  task automatic run(int o, int a, int m, int x, int t, bit n, bit v, bit z, bit c);
    logic [W+6:0] exp, got;
    @(negedge clk);
    op = 5'(o); acc = W'(a); opnd = W'(m); idx = W'(x); tgt = 2'(t);
    ni = n; vi = v; zi = z; ci = c;
    #2;
    exp = model(o, a, m, x, t, n, v, z, c);
    got = {vld, dst, no, vo, zo, co, res};
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h m=%h x=%h c=%b: got %h expected %h",
               tag(o), o, a, m, x, c, got, exp);
    end
  endtask

  initial begin
    op = '0; acc = '0; idx = '0; opnd = '0; tgt = '0;
    ni = 0; vi = 0; zi = 0; ci = 0;
    // idle vector: zero add gives zero result with Z set, R1
    run(0, 0, 0, 0, 0, 0, 0, 0, 0);
    // directed boundaries: signed overflow R1, borrow R2, equal compare R3
    run(0, 4'h7, 4'h1, 0, 0, 0, 0, 0, 0);
    run(0, 4'hF, 4'h1, 0, 0, 0, 0, 0, 0);
    run(1, 4'h8, 4'h1, 0, 0, 0, 0, 0, 1);
    run(1, 4'h0, 4'h0, 0, 0, 0, 0, 0, 0);
    run(2, 4'h5, 4'h5, 0, 0, 0, 1, 0, 0);
    run(18, 4'hF, 4'h3, 4'h3, 0, 0, 1, 0, 0); // R10 ignores carry in
    run(15, 4'h0, 4'h0, 4'h9, 0, 1, 1, 1, 1); // R8 quiet move
    for (int o = 0; o < 32; o++)
      for (int a = 0; a <= MSK; a++)
        for (int m = 0; m <= MSK; m++)
          for (int f = 0; f < 4; f++)
            for (int xi = 0; xi < 2; xi++)
              run(o, a, m, xi ? (a ^ 9) : (m ^ 3), (a + m) & 3,
                  ~f[0], f[1], f[1] ^ f[0], f[0]);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end
endmodule